// File: doc/BRIEF.md
# Balanced Ternary Word Adder

This unit performs arithmetic on signed words made of balanced ternary digits. Each digit takes one of the values −1, 0 or +1, so negative numbers need no complement form. Every digit travels on two binary wires. A word holds `NTRITS` digits, five by default. A five-digit word covers the 243 values from −121 to +121. The unit adds two words, subtracts them, negates the first word, or compares the two. Subtraction and comparison reuse the same ripple adder. They feed it the digit-wise inverse of the second operand. Negation feeds it the inverse of the first operand and zero.

The caller presents two operands and an operation code, then raises `in_valid` for one cycle. On the next clock edge the unit registers five outputs: the result word, a carry-out digit, a zero flag, a sign digit and an error flag. It also raises `res_valid` for one cycle. The zero flag is intended for a branch-on-zero decision.

A two-state machine tracks the output register. It moves from `S_IDLE` to `S_DONE` on transition `T_ACCEPT`, which is any cycle with `in_valid` high. It returns from `S_DONE` to `S_IDLE` on transition `T_RETIRE`, which is any cycle without `in_valid`. `S_DONE` stays in `S_DONE` while `in_valid` remains high. Reset forces `S_IDLE`.

Top module: `bt_word_alu`

## Requirements
- R1: Each digit is encoded on two bits: 2'b00 = 0, 2'b01 = +1, 2'b11 = −1. Digit i of a word occupies bits [2i+1:2i], with digit 0 the least significant. The result word never carries the code 2'b10.
- R2: With op = 2'b00 (add), the value 243·carry_out + result equals A + B for five-digit words. The result lies in −121..+121.
- R3: With op = 2'b01 (subtract), the value 243·carry_out + result equals A − B. The result lies in −121..+121.
- R4: With op = 2'b10 (negate), each digit of A is inverted independently (+1↔−1, 0 stays 0). carry_out is 0, and the value of B has no effect on the result.
- R5: With op = 2'b11 (compare), digit 0 of the result is −1 if A < B, 0 if A = B and +1 if A > B. All other digits and carry_out are 0.
- R6: zero is 1 exactly when carry_out and every result digit are 0.
- R7: sign is a digit. It equals carry_out when carry_out is non-zero. Otherwise it equals the most significant non-zero result digit, or 0 when the result is zero.
- R8: The outputs register on the clock edge that samples in_valid high. res_valid is 1 in the following cycle only when in_valid was 1.
- R9: While in_valid is low, result, carry_out, zero, sign and err hold their values.
- R10: If any digit of A or B carries the code 2'b10 when in_valid is high, err becomes 1 and result, carry_out, sign and zero become 0. A legal operation clears err.
- R11: A synchronous reset clears result, carry_out, zero, sign, err and res_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op are presented this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 negate A, 11 compare |
| opnd_a | input | 2·NTRITS | Operand A, two bits per digit |
| opnd_b | input | 2·NTRITS | Operand B, two bits per digit |
| result | output | 2·NTRITS | Result word |
| carry_out | output | 2 | Carry digit beyond the top result digit |
| zero | output | 1 | Full result (carry and word) is zero |
| sign | output | 2 | Sign of the full result as a digit |
| err | output | 1 | An illegal digit code was seen on the last accepted operands |
| res_valid | output | 1 | Outputs were updated on the last edge |

## Verification
On every cycle the assertions check the structural properties of the outputs. They check that result digits use only legal codes, and that res_valid tracks in_valid with one cycle of delay. They check that outputs hold while idle, and that a raised zero flag agrees with the word, carry and sign. They also check that an error clears the word, that a compare leaves the upper digits and the carry clear, and that reset clears all outputs. Only the bench can show that the arithmetic is right. It sweeps every operand pair for addition and comparison, a strided set for subtraction and every word for negation against an integer model. Directed cases then cover both overflow directions, illegal codes, holding and reset.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam logic [1:0] TRIT_Z   = 2'b00;
    localparam logic [1:0] TRIT_P   = 2'b01;
    localparam logic [1:0] TRIT_N   = 2'b11;
    localparam logic [1:0] TRIT_BAD = 2'b10;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_NEG = 2'b10,
        OP_CMP = 2'b11
    } bt_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } bt_state_e;

    // Digit-wise inversion: +1 <-> -1, 0 stays 0.
    function automatic logic [1:0] trit_neg(input logic [1:0] t);
        return {t[0] & ~t[1], t[0]};
    endfunction

    // Signed value of one digit code.
    function automatic logic signed [2:0] trit_val(input logic [1:0] t);
        case (t)
            TRIT_P:  return 3'sd1;
            TRIT_N:  return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/bt_digit_add.sv
module bt_digit_add
    import bt_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    input  logic [1:0] cin,
    output logic [1:0] s,
    output logic [1:0] cout
);

    logic signed [3:0] total;

    always_comb begin
        total = 4'(trit_val(a)) + 4'(trit_val(b)) + 4'(trit_val(cin));
        if (total > 4'sd1) begin
            cout = TRIT_P;
            s    = (total == 4'sd2) ? TRIT_N : TRIT_Z;
        end else if (total < -4'sd1) begin
            cout = TRIT_N;
            s    = (total == -4'sd2) ? TRIT_P : TRIT_Z;
        end else begin
            cout = TRIT_Z;
            s    = (total == 4'sd1) ? TRIT_P :
                   (total == -4'sd1) ? TRIT_N : TRIT_Z;
        end
    end

endmodule

// File: rtl/bt_ripple_add.sv
module bt_ripple_add
    import bt_pkg::*;
#(
    parameter int NTRITS = 5
) (
    input  logic [2*NTRITS-1:0] a,
    input  logic [2*NTRITS-1:0] b,
    output logic [2*NTRITS-1:0] sum,
    output logic [1:0]          cout
);

    logic [1:0] chain [0:NTRITS];

    assign chain[0] = TRIT_Z;

    for (genvar i = 0; i < NTRITS; i++) begin : g_digit
        bt_digit_add u_digit (
            .a    (a[2*i +: 2]),
            .b    (b[2*i +: 2]),
            .cin  (chain[i]),
            .s    (sum[2*i +: 2]),
            .cout (chain[i+1])
        );
    end

    assign cout = chain[NTRITS];

endmodule

// File: rtl/bt_sign_detect.sv
module bt_sign_detect
    import bt_pkg::*;
#(
    parameter int NTRITS = 5
) (
    input  logic [2*NTRITS-1:0] word,
    input  logic [1:0]          top,
    output logic [1:0]          sign,
    output logic                is_zero
);

    always_comb begin
        sign = TRIT_Z;
        for (int i = 0; i < NTRITS; i++) begin
            if (word[2*i +: 2] != TRIT_Z) sign = word[2*i +: 2];
        end
        if (top != TRIT_Z) sign = top;
        is_zero = (sign == TRIT_Z);
    end

endmodule

// File: rtl/bt_word_alu.sv
module bt_word_alu
    import bt_pkg::*;
#(
    parameter int NTRITS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          op,
    input  logic [2*NTRITS-1:0] opnd_a,
    input  logic [2*NTRITS-1:0] opnd_b,
    output logic [2*NTRITS-1:0] result,
    output logic [1:0]          carry_out,
    output logic                zero,
    output logic [1:0]          sign,
    output logic                err,
    output logic                res_valid
);

    localparam int W = 2 * NTRITS;

    bt_op_e      op_e;
    bt_state_e   state, state_nx;
    logic [W-1:0] add_a, add_b, add_sum;
    logic [1:0]   add_cout, sum_sign;
    logic         sum_zero, bad_code;
    logic [W-1:0] word_nx;
    logic [1:0]   carry_nx;

    assign op_e = bt_op_e'(op);

    // Operand preparation: subtract/compare invert B, negate inverts A.
    always_comb begin
        add_a = opnd_a;
        add_b = opnd_b;
        for (int i = 0; i < NTRITS; i++) begin
            unique case (op_e)
                OP_ADD: ;
                OP_SUB, OP_CMP: add_b[2*i +: 2] = trit_neg(opnd_b[2*i +: 2]);
                OP_NEG: begin
                    add_a[2*i +: 2] = trit_neg(opnd_a[2*i +: 2]);
                    add_b[2*i +: 2] = TRIT_Z;
                end
            endcase
        end
    end

    always_comb begin
        bad_code = 1'b0;
        for (int i = 0; i < NTRITS; i++) begin
            if (opnd_a[2*i +: 2] == TRIT_BAD || opnd_b[2*i +: 2] == TRIT_BAD)
                bad_code = 1'b1;
        end
    end

    bt_ripple_add #(.NTRITS(NTRITS)) u_adder (
        .a    (add_a),
        .b    (add_b),
        .sum  (add_sum),
        .cout (add_cout)
    );

    bt_sign_detect #(.NTRITS(NTRITS)) u_sign (
        .word    (add_sum),
        .top     (add_cout),
        .sign    (sum_sign),
        .is_zero (sum_zero)
    );

    // Compare places its verdict in digit 0 only.
    always_comb begin
        if (op_e == OP_CMP) begin
            word_nx        = '0;
            word_nx[1:0]   = sum_sign;
            carry_nx       = TRIT_Z;
        end else begin
            word_nx  = add_sum;
            carry_nx = add_cout;
        end
    end

    // Next-state logic: T_ACCEPT / T_RETIRE.
    always_comb begin
        unique case (state)
            S_IDLE:  state_nx = in_valid ? S_DONE : S_IDLE;
            S_DONE:  state_nx = in_valid ? S_DONE : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            carry_out <= TRIT_Z;
            zero      <= 1'b0;
            sign      <= TRIT_Z;
            err       <= 1'b0;
        end else if (in_valid) begin
            if (bad_code) begin
                result    <= '0;
                carry_out <= TRIT_Z;
                zero      <= 1'b0;
                sign      <= TRIT_Z;
                err       <= 1'b1;
            end else begin
                result    <= word_nx;
                carry_out <= carry_nx;
                zero      <= sum_zero;
                sign      <= sum_sign;
                err       <= 1'b0;
            end
        end
    end

    assign res_valid = (state == S_DONE);

endmodule

// File: rtl/bt_word_alu_chk.sv
module bt_word_alu_chk
    import bt_pkg::*;
#(
    parameter int NTRITS = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [1:0]          op,
    input logic [2*NTRITS-1:0] result,
    input logic [1:0]          carry_out,
    input logic                zero,
    input logic [1:0]          sign,
    input logic                err,
    input logic                res_valid
);

    function automatic logic word_legal(input logic [2*NTRITS-1:0] w);
        for (int i = 0; i < NTRITS; i++)
            if (w[2*i +: 2] == TRIT_BAD) return 1'b0;
        return 1'b1;
    endfunction

    a_r1_legal_codes: assert property (@(posedge clk) disable iff (rst)
        word_legal(result) && carry_out != TRIT_BAD && sign != TRIT_BAD);

    a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(carry_out) && $stable(zero)
                      && $stable(sign) && $stable(err));

    a_r6_zero_agrees: assert property (@(posedge clk) disable iff (rst)
        zero |-> (result == '0 && carry_out == TRIT_Z && sign == TRIT_Z));

    a_r10_err_clears: assert property (@(posedge clk) disable iff (rst)
        err |-> (result == '0 && !zero && carry_out == TRIT_Z));

    a_r5_cmp_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMP) |=>
            (result[2*NTRITS-1:2] == '0 && carry_out == TRIT_Z));

    a_r11_reset: assert property (@(posedge clk)
        rst |=> (result == '0 && carry_out == TRIT_Z && !zero && sign == TRIT_Z
                 && !err && !res_valid));

endmodule

bind bt_word_alu bt_word_alu_chk #(.NTRITS(NTRITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .result    (result),
    .carry_out (carry_out),
    .zero      (zero),
    .sign      (sign),
    .err       (err),
    .res_valid (res_valid)
);

// File: tb/bt_word_alu_bench.sv
module bt_word_alu_bench;

    localparam int N = 5;
    localparam int W = 2 * N;
    localparam int NVEC = 9;

    // op, a, b, expected word, expected carry, expected zero, expected sign
    localparam int VEC [NVEC][7] = '{
        '{0,    1,   -1,    0,  0, 1,  0},
        '{0,  121,  121,   -1,  1, 0,  1},
        '{0, -121, -121,    1, -1, 0, -1},
        '{1, -121,  121,    1, -1, 0, -1},
        '{2,  121,   40, -121,  0, 0, -1},
        '{3,    5,    5,    0,  0, 1,  0},
        '{3,   -3,    4,   -1,  0, 0, -1},
        '{0,    0,    0,    0,  0, 1,  0},
        '{0,   60,    1,   61,  0, 0,  1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic [1:0]   carry_out;
    logic         zero;
    logic [1:0]   sign;
    logic         err;
    logic         res_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic         pend = 1'b0;
    logic [W-1:0] e_word;
    logic [1:0]   e_carry;
    logic         e_zero;
    logic [1:0]   e_sign;
    string        e_tag;

    always #10 clk = ~clk;

    bt_word_alu #(.NTRITS(N)) u_bt_word_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_out(carry_out), .zero(zero), .sign(sign),
        .err(err), .res_valid(res_valid)
    );

    function automatic logic [1:0] enc_trit(input int t);
        return (t > 0) ? 2'b01 : (t < 0) ? 2'b11 : 2'b00;
    endfunction

    function automatic logic [W-1:0] enc_word(input int v);
        logic [W-1:0] w;
        int x;
        x = v;
        w = '0;
        for (int i = 0; i < N; i++) begin
            int r;
            r = ((x % 3) + 3) % 3;
            if (r == 2) r = -1;
            w[2*i +: 2] = enc_trit(r);
            x = (x - r) / 3;
        end
        return w;
    endfunction

    function automatic int sgn(input int v);
        return (v > 0) ? 1 : (v < 0) ? -1 : 0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            check(e_tag, {20'd0, carry_out, result}, {20'd0, e_carry, e_word});
            check("R6 zero", {31'd0, zero}, {31'd0, e_zero});
            check("R7 sign", {30'd0, sign}, {30'd0, e_sign});
            check("R8 res_valid", {31'd0, res_valid}, 32'd1);
            check("R10 err clear", {31'd0, err}, 32'd0);
            pend = 1'b0;
        end
    endtask

    // Reference model from the requirements.
    task automatic set_expect(input int o, input int a, input int b);
        int v, c, wv;
        case (o)
            0: begin v = a + b; e_tag = "R2 add"; end
            1: begin v = a - b; e_tag = "R3 sub"; end
            2: begin v = -a;    e_tag = "R4 neg"; end
            default: begin v = sgn(a - b); e_tag = "R5 cmp"; end
        endcase
        c = 0;
        wv = v;
        if (v > 121)  begin c = 1;  wv = v - 243; end
        if (v < -121) begin c = -1; wv = v + 243; end
        e_word  = enc_word(wv);
        e_carry = enc_trit(c);
        e_zero  = (v == 0);
        e_sign  = enc_trit(sgn(v));
    endtask

    task automatic issue(input int o, input int a, input int b);
        @(negedge clk);
        check_pending();
        op       = 2'(o);
        opnd_a   = enc_word(a);
        opnd_b   = enc_word(b);
        in_valid = 1'b1;
        set_expect(o, a, b);
        pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset result", {22'd0, result}, 32'd0);
        check("R11 reset valid", {31'd0, res_valid}, 32'd0);
        check("R11 reset flags", {28'd0, zero, err, sign}, 32'd0);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][0], VEC[i][1], VEC[i][2]);
            check("R2 table self", {22'd0, e_word}, {22'd0, enc_word(VEC[i][3])});
            checks--;
            @(negedge clk);
            check_pending();
            check("R7 table sign", {30'd0, sign}, {30'd0, enc_trit(VEC[i][6])});
            check("R6 table zero", {31'd0, zero}, 32'(VEC[i][5]));
            check("R1 table carry", {30'd0, carry_out}, {30'd0, enc_trit(VEC[i][4])});
            in_valid = 1'b0;
        end

        // Exhaustive add and compare, strided subtract, full negate
        for (int a = -121; a <= 121; a++)
            for (int b = -121; b <= 121; b++)
                issue(0, a, b);
        for (int a = -121; a <= 121; a++)
            for (int b = -121; b <= 121; b++)
                issue(3, a, b);
        for (int a = -121; a <= 121; a++)
            for (int b = -121; b <= 121; b += 11)
                issue(1, a, b);
        for (int a = -121; a <= 121; a++)
            issue(2, a, (a * 7) % 100);
        flush();

        // R9: hold while in_valid is low
        issue(0, 7, 8);
        flush();
        opnd_a = enc_word(-50);
        opnd_b = enc_word(33);
        op = 2'b01;
        repeat (3) @(negedge clk);
        check("R9 hold result", {22'd0, result}, {22'd0, enc_word(15)});
        check("R9 hold zero/sign", {29'd0, zero, sign}, {29'd0, 1'b0, 2'b01});
        check("R8 no valid when idle", {31'd0, res_valid}, 32'd0);

        // R10: illegal digit code
        opnd_a = enc_word(5);
        opnd_a[5:4] = 2'b10;
        opnd_b = enc_word(1);
        op = 2'b00;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 err set", {31'd0, err}, 32'd1);
        check("R10 result cleared", {20'd0, carry_out, result}, 32'd0);
        check("R10 zero/sign cleared", {29'd0, zero, sign}, 32'd0);
        opnd_a = '0;
        opnd_b[3:2] = 2'b10;
        op = 2'b10;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 err on B", {31'd0, err}, 32'd1);
        issue(0, 2, 2);
        flush();

        // R11: reset mid-run
        issue(0, 100, 100);
        flush();
        rst = 1'b1;
        @(negedge clk);
        check("R11 reset clears result", {20'd0, carry_out, result}, 32'd0);
        check("R11 reset clears flags", {27'd0, zero, sign, err, res_valid}, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule